// File: doc/BRIEF.md
# Read-Address Command Sequence Detector

This block watches the completed cycles of an asynchronous SRAM-style port and finds commands that software hides in a fixed, ordered run of six read addresses. Each completed cycle is presented for one clock as a strobe with its address, a write flag and the two read qualifiers: chip enable and output enable. Only the low 16 address bits take part in the match. The first five addresses are the same for every command. The sixth address picks one of two commands: a nonvolatile store, or switching on automatic store.

When the sixth address is accepted, the block raises a one-clock command strobe with the command code. In the same clock it raises busy, which blocks normal access. Busy lasts for a parameterised processing interval, then holds until the downstream transfer logic signals done. While busy is high every port cycle is ignored. When busy falls the matcher starts again from idle.

The controller has eight states. `S_IDLE` means nothing has matched yet. `S_GOT1` to `S_GOT5` mean that many prefix addresses have matched. `S_PROC` runs the processing interval and `S_WAIT_DONE` waits for done. The transitions are:
- ADVANCE: a read that matches the next expected prefix address moves from `S_IDLE` or `S_GOTk` to the next state.
- RESTART: a read that does not match returns to `S_IDLE`, or to `S_GOT1` if its address is the first prefix address.
- ABORT: any write returns the matcher to `S_IDLE`.
- FIRE: in `S_GOT5`, a read of either final address goes to `S_PROC` and raises the strobe.
- EXPIRE: at the end of the interval, `S_PROC` goes to `S_WAIT_DONE`, or straight to `S_IDLE` if done is already high.
- RELEASE: done moves `S_WAIT_DONE` to `S_IDLE`.

Top module: `rdseq_cmd_detect`

## Requirements
- R1: Synchronous active-high reset makes busy 0, the command strobe 0 and the command code 2'b00. The matcher returns to idle, so a partial sequence in progress is forgotten.
- R2: Six reads of 0x4E38, 0xB1C7, 0x83E0, 0x7C1F, 0x703F and then 0x8FC0 raise `cmd_strobe` for exactly one clock with `cmd_code` = 2'b01 (store). The strobe appears one clock after the edge that samples the sixth read.
- R3: The same five-address prefix followed by 0x4B46 raises `cmd_strobe` for one clock with `cmd_code` = 2'b10 (enable automatic store).
- R4: Only `cyc_addr[15:0]` is compared. The upper address bits may hold any value.
- R5: A cycle counts as a read when `cyc_valid`=1, `cyc_write`=0 and at least one of `cyc_ce_qual` or `cyc_oe_qual` is 1; either qualifier alone advances the matcher. A valid non-write cycle with neither qualifier, and any clock with `cyc_valid`=0, leaves the matcher unchanged.
- R6: A write cycle (`cyc_valid`=1, `cyc_write`=1) at any point returns the matcher to idle.
- R7: A read whose address does not match the expected position returns the matcher to idle. If that address is 0x4E38, the matcher goes to step 1 instead.
- R8: Busy rises together with the command strobe and stays high for exactly `PROC_CYCLES` clocks when done is high as the interval ends. Otherwise it stays high until the first edge that samples done high.
- R9: While busy is high, all cycles are ignored and no strobe can occur. When busy falls, the matcher is idle.
- R10: `cmd_code` is 2'b00 in every clock in which `cmd_strobe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_valid | input | 1 | One-clock pulse marking a completed port cycle |
| cyc_write | input | 1 | Completed cycle was a write |
| cyc_ce_qual | input | 1 | Cycle was qualified by chip enable |
| cyc_oe_qual | input | 1 | Cycle was qualified by output enable |
| cyc_addr | input | ADDR_W | Address of the completed cycle |
| xfer_done | input | 1 | Downstream transfer finished |
| cmd_strobe | output | 1 | One-clock command pulse |
| cmd_code | output | 2 | 01 store, 10 enable automatic store, 00 otherwise |
| busy | output | 1 | Soft-sequence processing; normal access disabled |

## Verification
The strobe and its code are registered. They are due one clock after the edge that samples the sixth read, so every check samples 1 ns after that edge. Busy rises in that same clock. The bench counts the busy clocks, sampled after each edge, until busy falls, and requires exactly `PROC_CYCLES` when done is held high. With done held low, busy must still be high several clocks past the interval, and it must fall one edge after done is raised. The ignore-while-busy check feeds a whole sequence during busy and then a sequence that has no head. Neither may produce a strobe.

// File: rtl/rdseq_pkg.sv
package rdseq_pkg;

    localparam int KEY_W      = 16;
    localparam int PREFIX_LEN = 5;

    localparam logic [KEY_W-1:0] KEY_FINAL_STORE  = 16'h8FC0;
    localparam logic [KEY_W-1:0] KEY_FINAL_AUTOEN = 16'h4B46;

    typedef enum logic [1:0] {
        CMD_NONE   = 2'b00,
        CMD_STORE  = 2'b01,
        CMD_AUTOEN = 2'b10
    } cmd_e;

    // Values 0..5 equal the count of prefix addresses matched so far.
    typedef enum logic [2:0] {
        S_IDLE      = 3'd0,
        S_GOT1      = 3'd1,
        S_GOT2      = 3'd2,
        S_GOT3      = 3'd3,
        S_GOT4      = 3'd4,
        S_GOT5      = 3'd5,
        S_PROC      = 3'd6,
        S_WAIT_DONE = 3'd7
    } state_e;

    function automatic logic [KEY_W-1:0] prefix_key(input int idx);
        logic [KEY_W-1:0] k;
        case (idx)
            0:       k = 16'h4E38;
            1:       k = 16'hB1C7;
            2:       k = 16'h83E0;
            3:       k = 16'h7C1F;
            4:       k = 16'h703F;
            default: k = '0;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/rdseq_key_match.sv
module rdseq_key_match
    import rdseq_pkg::*;
(
    input  logic [KEY_W-1:0] key_in,
    input  logic [2:0]       pos,
    output logic             hit_pos,
    output logic             hit_head,
    output logic             hit_store,
    output logic             hit_autoen
);

    logic [7:0] hit_vec;

    // One comparator per prefix step; unused slots stay at 0.
    generate
        for (genvar i = 0; i < 8; i++) begin : g_cmp
            if (i < PREFIX_LEN) begin : g_real
                assign hit_vec[i] = (key_in == prefix_key(i));
            end else begin : g_pad
                assign hit_vec[i] = 1'b0;
            end
        end
    endgenerate

    assign hit_pos    = hit_vec[pos];
    assign hit_head   = hit_vec[0];
    assign hit_store  = (key_in == KEY_FINAL_STORE);
    assign hit_autoen = (key_in == KEY_FINAL_AUTOEN);

    always_comb begin
        assert_keys_exclusive_R7: assert ($countones({hit_head, hit_store, hit_autoen}) <= 1)
            else $error("final and head keys overlap");
    end

endmodule

// File: rtl/rdseq_hold_timer.sv
module rdseq_hold_timer #(
    parameter int CYCLES = 10000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic run,
    output logic expired
);

    localparam int CNT_W = (CYCLES < 2) ? 1 : $clog2(CYCLES);
    localparam logic [CNT_W-1:0] LAST_C = CNT_W'(CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= '0;
        end else if (run && (cnt_q != LAST_C)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = run && (cnt_q == LAST_C);

    assert_count_bounded_R8: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST_C);

endmodule

// File: rtl/rdseq_cmd_detect.sv
module rdseq_cmd_detect
    import rdseq_pkg::*;
#(
    parameter int ADDR_W      = 19,
    parameter int PROC_CYCLES = 10000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cyc_valid,
    input  logic              cyc_write,
    input  logic              cyc_ce_qual,
    input  logic              cyc_oe_qual,
    input  logic [ADDR_W-1:0] cyc_addr,
    input  logic              xfer_done,
    output logic              cmd_strobe,
    output logic [1:0]        cmd_code,
    output logic              busy
);

    localparam int BL_W = $clog2(PROC_CYCLES + 1);
    localparam logic [BL_W-1:0] BL_CAP = BL_W'(PROC_CYCLES);

    state_e state_q, state_d;
    logic   is_read, is_wr;
    logic   hit_pos, hit_head, hit_store, hit_autoen;
    logic   fire_store, fire_autoen, tmr_start, tmr_expired;
    logic   strobe_q;
    cmd_e   code_q;

    generate
        if (ADDR_W > KEY_W) begin : g_hi
            logic unused_hi_bits;
            assign unused_hi_bits = ^cyc_addr[ADDR_W-1:KEY_W];
        end
    endgenerate

    assign is_read = cyc_valid && !cyc_write && (cyc_ce_qual || cyc_oe_qual);
    assign is_wr   = cyc_valid && cyc_write;
    assign busy    = (state_q == S_PROC) || (state_q == S_WAIT_DONE);

    rdseq_key_match u_match (
        .key_in     (cyc_addr[KEY_W-1:0]),
        .pos        (state_q),
        .hit_pos    (hit_pos),
        .hit_head   (hit_head),
        .hit_store  (hit_store),
        .hit_autoen (hit_autoen)
    );

    rdseq_hold_timer #(.CYCLES(PROC_CYCLES)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .start   (tmr_start),
        .run     (state_q == S_PROC),
        .expired (tmr_expired)
    );

    always_comb begin
        state_d     = state_q;
        fire_store  = 1'b0;
        fire_autoen = 1'b0;
        unique case (state_q)
            S_IDLE, S_GOT1, S_GOT2, S_GOT3, S_GOT4: begin
                if (is_wr) begin
                    state_d = S_IDLE;                        // ABORT
                end else if (is_read) begin
                    if (hit_pos)       state_d = state_e'(state_q + 3'd1); // ADVANCE
                    else if (hit_head) state_d = S_GOT1;     // RESTART
                    else               state_d = S_IDLE;
                end
            end
            S_GOT5: begin
                if (is_wr) begin
                    state_d = S_IDLE;
                end else if (is_read) begin
                    if (hit_store) begin                     // FIRE
                        state_d    = S_PROC;
                        fire_store = 1'b1;
                    end else if (hit_autoen) begin
                        state_d     = S_PROC;
                        fire_autoen = 1'b1;
                    end else if (hit_head) begin
                        state_d = S_GOT1;
                    end else begin
                        state_d = S_IDLE;
                    end
                end
            end
            S_PROC: begin
                if (tmr_expired) state_d = xfer_done ? S_IDLE : S_WAIT_DONE; // EXPIRE
            end
            S_WAIT_DONE: begin
                if (xfer_done) state_d = S_IDLE;             // RELEASE
            end
        endcase
    end

    assign tmr_start = fire_store || fire_autoen;

    always_ff @(posedge clk) begin
        if (rst) state_q <= S_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_q <= 1'b0;
            code_q   <= CMD_NONE;
        end else begin
            strobe_q <= fire_store || fire_autoen;
            code_q   <= fire_store  ? CMD_STORE  :
                        fire_autoen ? CMD_AUTOEN : CMD_NONE;
        end
    end

    assign cmd_strobe = strobe_q;
    assign cmd_code   = code_q;

    // Length of the current busy stretch, saturating at the interval.
    logic [BL_W-1:0] busy_len_q;
    always_ff @(posedge clk) begin
        if (rst || !busy)           busy_len_q <= '0;
        else if (busy_len_q != BL_CAP) busy_len_q <= busy_len_q + 1'b1;
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!busy && !cmd_strobe && cmd_code == CMD_NONE));

    assert_strobe_single_R2: assert property (@(posedge clk) disable iff (rst)
        cmd_strobe |=> !cmd_strobe);

    assert_write_abort_R6: assert property (@(posedge clk) disable iff (rst)
        (is_wr && !busy) |=> (state_q == S_IDLE));

    assert_busy_with_strobe_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> cmd_strobe);

    assert_busy_min_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (busy_len_q == BL_CAP));

    assert_ignore_busy_R9: assert property (@(posedge clk) disable iff (rst)
        busy |=> !cmd_strobe);

    assert_code_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !cmd_strobe |-> (cmd_code == CMD_NONE));

endmodule

// File: tb/rdseq_cmd_detect_tb_top.sv
module rdseq_cmd_detect_tb_top;

    localparam int AW   = 20;
    localparam int PROC = 16;
    localparam int NV   = 55;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cyc_valid = 1'b0, cyc_write = 1'b0, cyc_ce_qual = 1'b0, cyc_oe_qual = 1'b0;
    logic [AW-1:0] cyc_addr = '0;
    logic          xfer_done = 1'b1;
    logic          cmd_strobe, busy;
    logic [1:0]    cmd_code;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    rdseq_cmd_detect #(.ADDR_W(AW), .PROC_CYCLES(PROC)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .cyc_valid   (cyc_valid),
        .cyc_write   (cyc_write),
        .cyc_ce_qual (cyc_ce_qual),
        .cyc_oe_qual (cyc_oe_qual),
        .cyc_addr    (cyc_addr),
        .xfer_done   (xfer_done),
        .cmd_strobe  (cmd_strobe),
        .cmd_code    (cmd_code),
        .busy        (busy)
    );

    // Vector: {req[3:0], valid, write, ce, oe, addr[19:0], exp_strobe, exp_code[1:0]}
    function automatic logic [30:0] vec(input logic [3:0] rq, input logic v, w, ce, oe,
                                        input logic [19:0] a, input logic es,
                                        input logic [1:0] ec);
        return {rq, v, w, ce, oe, a, es, ec};
    endfunction

    function automatic string req_name(input logic [3:0] rq);
        case (rq)
            4'd1: return "R1";   4'd2: return "R2";   4'd3: return "R3";
            4'd4: return "R4";   4'd5: return "R5";   4'd6: return "R6";
            4'd7: return "R7";   4'd8: return "R8";   4'd9: return "R9";
            default: return "R10";
        endcase
    endfunction

    localparam logic [30:0] TBL [NV] = '{
        // R2: store via chip-enable reads
        vec(2,1,0,1,0,20'h04E38,0,0), vec(2,1,0,1,0,20'h0B1C7,0,0), vec(2,1,0,1,0,20'h083E0,0,0),
        vec(2,1,0,1,0,20'h07C1F,0,0), vec(2,1,0,1,0,20'h0703F,0,0), vec(2,1,0,1,0,20'h08FC0,1,1),
        // R3 and R5: enable-autostore via output-enable reads only
        vec(3,1,0,0,1,20'h04E38,0,0), vec(3,1,0,0,1,20'h0B1C7,0,0), vec(3,1,0,0,1,20'h083E0,0,0),
        vec(3,1,0,0,1,20'h07C1F,0,0), vec(3,1,0,0,1,20'h0703F,0,0), vec(3,1,0,0,1,20'h04B46,1,2),
        // R4: upper address bits vary
        vec(4,1,0,1,1,20'hF4E38,0,0), vec(4,1,0,1,1,20'hAB1C7,0,0), vec(4,1,0,1,1,20'h383E0,0,0),
        vec(4,1,0,1,1,20'h17C1F,0,0), vec(4,1,0,1,1,20'hC703F,0,0), vec(4,1,0,1,1,20'h58FC0,1,1),
        // R6: write in the middle aborts
        vec(6,1,0,1,0,20'h04E38,0,0), vec(6,1,0,1,0,20'h0B1C7,0,0), vec(6,1,1,1,0,20'h083E0,0,0),
        vec(6,1,0,1,0,20'h083E0,0,0), vec(6,1,0,1,0,20'h07C1F,0,0), vec(6,1,0,1,0,20'h0703F,0,0),
        vec(6,1,0,1,0,20'h08FC0,0,0),
        // R7: repeated head restarts at step 1
        vec(7,1,0,1,0,20'h04E38,0,0), vec(7,1,0,1,0,20'h0B1C7,0,0), vec(7,1,0,1,0,20'h04E38,0,0),
        vec(7,1,0,1,0,20'h0B1C7,0,0), vec(7,1,0,1,0,20'h083E0,0,0), vec(7,1,0,1,0,20'h07C1F,0,0),
        vec(7,1,0,1,0,20'h0703F,0,0), vec(7,1,0,1,0,20'h04B46,1,2),
        // R5: unqualified cycle and idle clock do not disturb
        vec(5,1,0,1,0,20'h04E38,0,0), vec(5,1,0,0,0,20'h01234,0,0), vec(5,0,0,0,0,20'h0FFFF,0,0),
        vec(5,1,0,0,1,20'h0B1C7,0,0), vec(5,1,0,1,0,20'h083E0,0,0), vec(5,1,0,0,1,20'h07C1F,0,0),
        vec(5,1,0,1,0,20'h0703F,0,0), vec(5,1,0,0,1,20'h08FC0,1,1),
        // R7: wrong sixth address
        vec(7,1,0,1,0,20'h04E38,0,0), vec(7,1,0,1,0,20'h0B1C7,0,0), vec(7,1,0,1,0,20'h083E0,0,0),
        vec(7,1,0,1,0,20'h07C1F,0,0), vec(7,1,0,1,0,20'h0703F,0,0), vec(7,1,0,1,0,20'h01111,0,0),
        vec(7,1,0,1,0,20'h08FC0,0,0),
        // R7: wrong middle address
        vec(7,1,0,1,0,20'h04E38,0,0), vec(7,1,0,1,0,20'h0B1C7,0,0), vec(7,1,0,1,0,20'h09999,0,0),
        vec(7,1,0,1,0,20'h083E0,0,0), vec(7,1,0,1,0,20'h07C1F,0,0), vec(7,1,0,1,0,20'h0703F,0,0),
        vec(7,1,0,1,0,20'h08FC0,0,0)
    };

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp,
                         input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic drive(input logic v, w, ce, oe, input logic [AW-1:0] a);
        @(negedge clk);
        cyc_valid = v; cyc_write = w; cyc_ce_qual = ce; cyc_oe_qual = oe; cyc_addr = a;
        @(posedge clk);
        #1;
        cyc_valid = 1'b0; cyc_write = 1'b0;
    endtask

    task automatic read(input logic [AW-1:0] a);
        drive(1'b1, 1'b0, 1'b1, 1'b0, a);
    endtask

    // Count busy clocks, the first one already sampled by the caller.
    task automatic busy_length(output int n);
        n = busy ? 1 : 0;
        while (busy && n < 1000) begin
            @(posedge clk);
            #1;
            if (busy) n++;
        end
    endtask

    task automatic prefix();
        read(20'h04E38); read(20'h0B1C7); read(20'h083E0); read(20'h07C1F); read(20'h0703F);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check("R1", {31'd0, busy}, 32'd0, "busy after reset");
        check("R1", {31'd0, cmd_strobe}, 32'd0, "strobe after reset");
        check("R1", {30'd0, cmd_code}, 32'd0, "code after reset");
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            logic [30:0] t;
            t = TBL[i];
            drive(t[26], t[25], t[24], t[23], t[22:3]);
            check(req_name(t[30:27]), {31'd0, cmd_strobe}, {31'd0, t[2]}, "strobe");
            check(t[2] ? req_name(t[30:27]) : "R10", {30'd0, cmd_code}, {30'd0, t[1:0]}, "code");
            if (t[2]) begin
                busy_length(n);
                check("R8", n, PROC, "busy length");
            end
        end

        // R1: reset in mid-sequence forgets progress
        prefix();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        read(20'h08FC0);
        check("R1", {31'd0, cmd_strobe}, 32'd0, "strobe after mid-sequence reset");

        // R8: busy holds until done
        xfer_done = 1'b0;
        prefix(); read(20'h08FC0);
        check("R2", {31'd0, cmd_strobe}, 32'd1, "strobe before done wait");
        repeat (PROC + 3) @(posedge clk);
        #1;
        check("R8", {31'd0, busy}, 32'd1, "busy held without done");
        @(negedge clk); xfer_done = 1'b1;
        @(posedge clk); #1;
        check("R8", {31'd0, busy}, 32'd0, "busy released by done");

        // R9: cycles ignored while busy, idle afterwards
        prefix(); read(20'h04B46);
        check("R3", {30'd0, cmd_code}, 32'd2, "code before busy test");
        prefix(); read(20'h08FC0); read(20'h04E38);
        check("R9", {31'd0, busy}, 32'd1, "still busy during ignored reads");
        n = 0;
        while (busy && n < 1000) begin
            @(posedge clk); #1;
            n++;
        end
        read(20'h0B1C7); read(20'h083E0); read(20'h07C1F); read(20'h0703F); read(20'h08FC0);
        check("R9", {31'd0, cmd_strobe}, 32'd0, "no strobe from state kept over busy");
        prefix(); read(20'h08FC0);
        check("R9", {31'd0, cmd_strobe}, 32'd1, "matcher live after busy");
        busy_length(n);
        check("R8", n, PROC, "busy length after R9 test");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule